// File: doc/BRIEF.md
# Interrupt Acknowledge and Completion Port

This block is the per-processor side of an interrupt controller. A distributor presents, for every source, a pending flag that already accounts for enable and targeting, together with the source's priority byte and the number of the processor that raised it. The port selects the best candidate among the pending sources that are not already in service. It gates that candidate with a programmable priority threshold and with the priority of the interrupt currently being serviced, and drives a single request line toward the processor.

Software works through a 32-bit register bus. A read of the claim register takes the winning source atomically: the source becomes active, the distributor receives a one-cycle claim strobe so that it can drop an edge-style pending flag, and the running priority rises to the claimed source's level. A write of the same value to the completion register retires the most recently claimed source and restores the running priority it replaced. Active sources are held on a stack whose depth is a parameter, so handlers can nest by preemption. Only the upper `PRIO_BITS` bits of each priority byte take part in any comparison.

Top module: `irq_cpu_port`

## Requirements
- R1: After reset the enable bit is 0, the threshold reads 0x00, the running priority reads 0xFF, `irq_out` is low and a claim read returns 1023.
- R2: The candidate is the pending, non-active source with the numerically lowest effective priority, where the effective priority keeps only bits 7:4 of the byte (with `PRIO_BITS` = 4). On equal effective priority the lower source number wins.
- R3: `irq_out` is high exactly when the enable bit (offset 0x00, bit 0) is set, a candidate exists, its effective priority is below the threshold, it is below the running priority, and the active stack is not full.
- R4: A read at offset 0x0C while `irq_out` is high returns the candidate number in bits 9:0 and its requester number (`src_cpu` field) in bits 12:10 with zeros above. In the same cycle `claim_pulse` is high with `claim_id` equal to that number, and the source becomes active.
- R5: A read at offset 0x0C while `irq_out` is low returns 1023 with all other bits zero, raises no claim and changes no state.
- R6: Offset 0x14 reads 0xFF while nothing is active, and otherwise the effective priority of the most recently claimed source that is still active.
- R7: A write at offset 0x10 whose bits 9:0 equal the most recently claimed active source retires it, and the running priority returns to the value it had before that claim.
- R8: A write at offset 0x10 with any other number, or while nothing is active, has no effect on the running priority or the active set.
- R9: Offset 0x18 returns the candidate of R2 in the layout of R4 (or 1023 if there is none) regardless of enable, threshold and running priority, and claims nothing.
- R10: Offset 0x00 bit 0 holds the enable bit and offset 0x04 holds the threshold; both read back what was written, the threshold with bits 3:0 forced to zero.
- R11: When `DEPTH` sources are active, `irq_out` stays low and a claim read returns 1023 even if a better source is pending.
- R12: A source that is active is never a candidate, even while its pending flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NSRC | Pending, enabled and targeted flag per source |
| src_prio | input | 8*NSRC | Priority byte per source, source i at bits 8i+7:8i |
| src_cpu | input | 3*NSRC | Requester number per source, source i at bits 3i+2:3i |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | 1 | Interrupt request to the processor |
| claim_pulse | output | 1 | High in the cycle a claim read takes a source |
| claim_id | output | 10 | Source taken by the claim |

## Verification
The bench builds the port with 16 sources, a four-entry active stack and four implemented priority bits. The shallow stack lets a directed sequence of four nested claims fill it, so the full-stack case of R11 is reached with an even better source still pending. Sixteen sources keep equal upper nibbles frequent under random priorities, which exercises the tie rule and the masking of the low nibble. Random runs also interleave mismatched completion writes, threshold changes and sources that stay pending while active.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
   localparam int ID_W  = 10;
   localparam int CPU_W = 3;
   localparam logic [ID_W-1:0] ID_NONE = 10'd1023;

   localparam logic [7:0] OFF_CTRL = 8'h00;
   localparam logic [7:0] OFF_MASK = 8'h04;
   localparam logic [7:0] OFF_ACK  = 8'h0C;
   localparam logic [7:0] OFF_EOI  = 8'h10;
   localparam logic [7:0] OFF_RUN  = 8'h14;
   localparam logic [7:0] OFF_PEEK = 8'h18;

   typedef struct packed {
      logic [ID_W-1:0] id;
      logic [7:0]      prio;
   } act_ent_t;
endpackage

// File: rtl/irq_cpu_pick.sv
module irq_cpu_pick
   import irq_cpu_pkg::*;
#(
   parameter int NSRC      = 32,
   parameter int PRIO_BITS = 4
) (
   input  logic [NSRC-1:0]   cand,
   input  logic [NSRC*8-1:0] prio,
   output logic              found,
   output logic [ID_W-1:0]   best_id,
   output logic [7:0]        best_prio
);
   localparam logic [7:0] KEEP = 8'(8'hFF << (8 - PRIO_BITS));

   logic [7:0] eff [NSRC];

   for (genvar i = 0; i < NSRC; i++) begin : g_eff
      if (PRIO_BITS == 8) begin : g_full
         assign eff[i] = prio[i*8 +: 8];
      end else begin : g_trim
         assign eff[i] = prio[i*8 +: 8] & KEEP;
      end
   end

   // ascending scan with strict compare: lowest number wins a tie
   always_comb begin
      found     = 1'b0;
      best_id   = '0;
      best_prio = 8'hFF;
      for (int i = 0; i < NSRC; i++) begin
         if (cand[i] && (!found || eff[i] < best_prio)) begin
            found     = 1'b1;
            best_id   = ID_W'(i);
            best_prio = eff[i];
         end
      end
   end
endmodule

// File: rtl/irq_cpu_stack.sv
module irq_cpu_stack
   import irq_cpu_pkg::*;
#(
   parameter int NSRC  = 32,
   parameter int DEPTH = 16,
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [ID_W-1:0]  push_id,
   input  logic [7:0]       push_prio,
   input  logic             pop,
   output logic [CNT_W-1:0] count,
   output logic             empty,
   output logic             full,
   output logic [ID_W-1:0]  top_id,
   output logic [7:0]       top_prio,
   output logic [NSRC-1:0]  act_mask
);
   act_ent_t ent [DEPTH];

   assign empty = (count == '0);
   assign full  = (count == CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count <= '0;
         for (int j = 0; j < DEPTH; j++) ent[j] <= '0;
      end else if (push && !full) begin
         for (int j = 0; j < DEPTH; j++)
            if (count == CNT_W'(j)) ent[j] <= '{id: push_id, prio: push_prio};
         count <= count + 1'b1;
      end else if (pop && !empty) begin
         count <= count - 1'b1;
      end
   end

   always_comb begin
      top_id   = '0;
      top_prio = 8'hFF;
      for (int j = 0; j < DEPTH; j++) begin
         if (count == CNT_W'(j + 1)) begin
            top_id   = ent[j].id;
            top_prio = ent[j].prio;
         end
      end
   end

   always_comb begin
      act_mask = '0;
      for (int j = 0; j < DEPTH; j++)
         for (int i = 0; i < NSRC; i++)
            if (CNT_W'(j) < count && ent[j].id == ID_W'(i)) act_mask[i] = 1'b1;
   end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
   import irq_cpu_pkg::*;
#(
   parameter int NSRC      = 32,
   parameter int DEPTH     = 16,
   parameter int PRIO_BITS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NSRC-1:0]      src_pend,
   input  logic [NSRC*8-1:0]    src_prio,
   input  logic [NSRC*CPU_W-1:0] src_cpu,
   input  logic                 bus_en,
   input  logic                 bus_we,
   input  logic [7:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   output logic [31:0]          bus_rdata,
   output logic                 irq_out,
   output logic                 claim_pulse,
   output logic [ID_W-1:0]      claim_id
);
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [7:0] KEEP = 8'(8'hFF << (8 - PRIO_BITS));

   if (NSRC < 1 || NSRC > 1020) begin : g_bad_nsrc
      $error("NSRC must lie in 1..1020");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (PRIO_BITS < 1 || PRIO_BITS > 8) begin : g_bad_pb
      $error("PRIO_BITS must lie in 1..8");
   end

   logic             ctrl_en;
   logic [7:0]       pmask;
   logic [NSRC-1:0]  act_mask;
   logic [CNT_W-1:0] act_cnt;
   logic             st_empty, st_full;
   logic [ID_W-1:0]  top_id;
   logic [7:0]       top_prio;
   logic             found;
   logic [ID_W-1:0]  best_id;
   logic [7:0]       best_prio;
   logic [CPU_W-1:0] best_cpu;
   logic [7:0]       run_prio;
   logic             qualify, rd_ack, wr_eoi, pop;
   logic [31:0]      ack_word, peek_word;

   irq_cpu_pick #(.NSRC(NSRC), .PRIO_BITS(PRIO_BITS)) u_pick (
      .cand      (src_pend & ~act_mask),
      .prio      (src_prio),
      .found     (found),
      .best_id   (best_id),
      .best_prio (best_prio)
   );

   irq_cpu_stack #(.NSRC(NSRC), .DEPTH(DEPTH)) u_stack (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (claim_pulse),
      .push_id   (best_id),
      .push_prio (best_prio),
      .pop       (pop),
      .count     (act_cnt),
      .empty     (st_empty),
      .full      (st_full),
      .top_id    (top_id),
      .top_prio  (top_prio),
      .act_mask  (act_mask)
   );

   always_comb begin
      best_cpu = '0;
      for (int i = 0; i < NSRC; i++)
         if (best_id == ID_W'(i)) best_cpu = src_cpu[i*CPU_W +: CPU_W];
   end

   assign run_prio = st_empty ? 8'hFF : top_prio;
   assign qualify  = ctrl_en && found && !st_full &&
                     (best_prio < pmask) && (best_prio < run_prio);

   assign rd_ack = bus_en && !bus_we && (bus_addr == OFF_ACK);
   assign wr_eoi = bus_en && bus_we && (bus_addr == OFF_EOI);
   assign pop    = wr_eoi && !st_empty && (bus_wdata[ID_W-1:0] == top_id);

   assign irq_out     = qualify;
   assign claim_pulse = rd_ack && qualify;
   assign claim_id    = best_id;

   assign peek_word = found ? {19'b0, best_cpu, best_id} : {22'b0, ID_NONE};
   assign ack_word  = qualify ? peek_word : {22'b0, ID_NONE};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_en <= 1'b0;
         pmask   <= 8'h00;
      end else if (bus_en && bus_we) begin
         if (bus_addr == OFF_CTRL) ctrl_en <= bus_wdata[0];
         if (bus_addr == OFF_MASK) pmask   <= bus_wdata[7:0] & KEEP;
      end
   end

   always_comb begin
      unique case (bus_addr)
         OFF_CTRL: bus_rdata = {31'b0, ctrl_en};
         OFF_MASK: bus_rdata = {24'b0, pmask};
         OFF_ACK:  bus_rdata = ack_word;
         OFF_RUN:  bus_rdata = {24'b0, run_prio};
         OFF_PEEK: bus_rdata = peek_word;
         default:  bus_rdata = 32'b0;
      endcase
   end
endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk
   import irq_cpu_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_en,
   input logic             bus_we,
   input logic [7:0]       bus_addr,
   input logic [31:0]      bus_wdata,
   input logic [31:0]      bus_rdata,
   input logic             irq_out,
   input logic             claim_pulse,
   input logic             ctrl_en,
   input logic [CNT_W-1:0] act_cnt,
   input logic [ID_W-1:0]  top_id
);
   logic ack_rd, eoi_wr;
   assign ack_rd = bus_en && !bus_we && bus_addr == OFF_ACK;
   assign eoi_wr = bus_en && bus_we && bus_addr == OFF_EOI;

   p_claim_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      claim_pulse |-> ack_rd);

   p_claim_pushes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      claim_pulse |=> act_cnt == $past(act_cnt) + 1'b1);

   p_spurious_value_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && !claim_pulse) |-> bus_rdata == 32'd1023);

   p_irq_needs_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ctrl_en);

   p_full_is_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      act_cnt == CNT_W'(DEPTH) |-> !irq_out);

   p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
      act_cnt <= CNT_W'(DEPTH));

   p_eoi_hit_pops_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && act_cnt != '0 && bus_wdata[ID_W-1:0] == top_id)
      |=> act_cnt == $past(act_cnt) - 1'b1);

   p_eoi_miss_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && (act_cnt == '0 || bus_wdata[ID_W-1:0] != top_id))
      |=> $stable(act_cnt));
endmodule

bind irq_cpu_port irq_cpu_port_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .bus_en      (bus_en),
   .bus_we      (bus_we),
   .bus_addr    (bus_addr),
   .bus_wdata   (bus_wdata),
   .bus_rdata   (bus_rdata),
   .irq_out     (irq_out),
   .claim_pulse (claim_pulse),
   .ctrl_en     (ctrl_en),
   .act_cnt     (act_cnt),
   .top_id      (top_id)
);

// File: tb/irq_cpu_port_bench.sv
`timescale 1ns/1ps
module irq_cpu_port_bench;
   localparam int NSRC = 16;
   localparam int DEPTH = 4;
   localparam int PB = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NSRC-1:0]   pend = '0;
   logic [NSRC*8-1:0] prio_v = '0;
   logic [NSRC*3-1:0] cpu_v = '0;
   logic bus_en = 1'b0, bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq_out, claim_pulse;
   logic [9:0] claim_id;

   int checks = 0, fails = 0;
   logic [NSRC-1:0] edge_t = '0;

   // model state
   logic       m_en = 1'b0;
   logic [7:0] m_mask = 8'h00;
   int         m_sp = 0;
   int         m_id [DEPTH];
   logic [7:0] m_pr [DEPTH];
   logic       e_found;
   int         e_id;
   logic [7:0] e_prio;

   always #2 clk = ~clk;

   irq_cpu_port #(.NSRC(NSRC), .DEPTH(DEPTH), .PRIO_BITS(PB)) u_irq_cpu_port (
      .clk, .rst_n, .src_pend(pend), .src_prio(prio_v), .src_cpu(cpu_v),
      .bus_en, .bus_we, .bus_addr, .bus_wdata, .bus_rdata,
      .irq_out, .claim_pulse, .claim_id
   );

   task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   function automatic logic [7:0] run_p();
      return (m_sp == 0) ? 8'hFF : m_pr[m_sp-1];
   endfunction

   function automatic logic is_active(input int s);
      for (int j = 0; j < m_sp; j++) if (m_id[j] == s) return 1'b1;
      return 1'b0;
   endfunction

   task automatic pick();
      e_found = 1'b0; e_id = 0; e_prio = 8'hFF;
      for (int s = 0; s < NSRC; s++) begin
         logic [7:0] p;
         p = prio_v[s*8 +: 8] & 8'hF0;
         if (pend[s] && !is_active(s) && (!e_found || p < e_prio)) begin
            e_found = 1'b1; e_id = s; e_prio = p;
         end
      end
   endtask

   function automatic logic [31:0] word_of(input int s);
      return {19'b0, cpu_v[s*3 +: 3], 10'(s)};
   endfunction

   // one bus access; tag overrides the automatic requirement label
   task automatic step(input logic we, input logic [7:0] addr, input logic [31:0] wd, input string tag);
      logic qual;
      logic [31:0] exp;
      string t;
      @(negedge clk);
      bus_en = 1'b1; bus_we = we; bus_addr = addr; bus_wdata = wd;
      #1;
      pick();
      qual = m_en && e_found && e_prio < m_mask && e_prio < run_p() && m_sp < DEPTH;
      chk(irq_out == qual, (tag != "") ? tag : "R3", {31'b0, irq_out}, {31'b0, qual});
      if (!we) begin
         case (addr)
            8'h00: begin exp = {31'b0, m_en}; t = "R10"; end
            8'h04: begin exp = {24'b0, m_mask}; t = "R10"; end
            8'h0C: begin exp = qual ? word_of(e_id) : 32'd1023;
                         t = qual ? "R4" : ((m_sp == DEPTH) ? "R11" : "R5"); end
            8'h14: begin exp = {24'b0, run_p()}; t = "R6"; end
            8'h18: begin exp = e_found ? word_of(e_id) : 32'd1023; t = "R9"; end
            default: begin exp = 32'd0; t = "R10"; end
         endcase
         if (tag != "") t = tag;
         chk(bus_rdata == exp, t, bus_rdata, exp);
         if (addr == 8'h0C) begin
            chk(claim_pulse == qual, (qual ? "R4" : "R5"), {31'b0, claim_pulse}, {31'b0, qual});
            if (qual) chk(claim_id == 10'(e_id), "R4", {22'b0, claim_id}, e_id);
         end
      end else begin
         chk(claim_pulse == 1'b0, "R4", {31'b0, claim_pulse}, 32'd0);
      end
      // model update for the coming edge
      if (we && addr == 8'h00) m_en = wd[0];
      if (we && addr == 8'h04) m_mask = wd[7:0] & 8'hF0;
      if (we && addr == 8'h10 && m_sp > 0 && int'(wd[9:0]) == m_id[m_sp-1]) m_sp--;
      @(posedge clk);
      #1;
      bus_en = 1'b0; bus_we = 1'b0;
      if (!we && addr == 8'h0C && qual) begin
         m_id[m_sp] = e_id; m_pr[m_sp] = e_prio; m_sp++;
         if (edge_t[e_id]) pend[e_id] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_up();
   end

   initial begin
      void'($urandom(32'h0C0FFEE1));
      for (int s = 0; s < NSRC; s++) cpu_v[s*3 +: 3] = 3'($urandom % 8);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1 reset state
      step(1'b0, 8'h00, 0, "R1");
      step(1'b0, 8'h04, 0, "R1");
      step(1'b0, 8'h14, 0, "R1");
      step(1'b0, 8'h0C, 0, "R1");

      // R2 tie and low nibble, R9 peek, R4 claim
      prio_v[3*8 +: 8] = 8'h4F; prio_v[5*8 +: 8] = 8'h40; prio_v[9*8 +: 8] = 8'h80;
      pend = '0; pend[3] = 1; pend[5] = 1; pend[9] = 1;
      step(1'b0, 8'h18, 0, "R2");
      step(1'b0, 8'h0C, 0, "");           // disabled: R5
      step(1'b1, 8'h00, 32'h1, "");
      step(1'b1, 8'h04, 32'hFF, "");
      step(1'b0, 8'h04, 0, "R10");        // reads 0xF0
      step(1'b0, 8'h0C, 0, "R2");         // takes 3
      step(1'b0, 8'h14, 0, "R6");
      step(1'b0, 8'h0C, 0, "R5");         // 5 equals running priority
      step(1'b0, 8'h18, 0, "R12");        // 3 still pending but active
      step(1'b1, 8'h10, 32'd9, "R8");
      step(1'b0, 8'h14, 0, "R8");
      step(1'b1, 8'h10, 32'd3, "R7");
      step(1'b0, 8'h14, 0, "R7");
      // threshold gating
      step(1'b1, 8'h04, 32'h40, "");
      step(1'b0, 8'h0C, 0, "R3");
      step(1'b1, 8'h04, 32'hF0, "");

      // R11 fill the stack by nesting
      pend = '0;
      prio_v[1*8 +: 8] = 8'hD0; prio_v[2*8 +: 8] = 8'hA0;
      prio_v[6*8 +: 8] = 8'h60; prio_v[7*8 +: 8] = 8'h20; prio_v[8*8 +: 8] = 8'h10;
      pend[1] = 1; step(1'b0, 8'h0C, 0, "R4");
      pend[2] = 1; step(1'b0, 8'h0C, 0, "R4");
      pend[6] = 1; step(1'b0, 8'h0C, 0, "R4");
      pend[7] = 1; step(1'b0, 8'h0C, 0, "R4");
      pend[8] = 1; step(1'b0, 8'h0C, 0, "R11");
      step(1'b0, 8'h14, 0, "R11");
      step(1'b1, 8'h10, 32'd7, "R7");
      step(1'b0, 8'h0C, 0, "R4");          // 8 now fits
      for (int k = 0; k < DEPTH; k++) step(1'b1, 8'h10, {22'b0, 10'(m_sp > 0 ? m_id[m_sp-1] : 0)}, "R7");
      step(1'b0, 8'h14, 0, "R6");

      // random traffic
      edge_t = 16'($urandom);
      for (int s = 0; s < NSRC; s++) prio_v[s*8 +: 8] = 8'($urandom);
      for (int n = 0; n < 4000; n++) begin
         int r;
         if ($urandom % 3 == 0) pend[$urandom % NSRC] = 1'($urandom);
         if (n % 700 == 0) prio_v[($urandom % NSRC)*8 +: 8] = 8'($urandom);
         r = $urandom % 12;
         case (r)
            0, 1, 2, 3: step(1'b0, 8'h0C, 0, "");
            4, 5: step(1'b1, 8'h10,
                       {22'b0, 10'((m_sp > 0 && $urandom % 3 != 0) ? m_id[m_sp-1] : $urandom % 1024)}, "");
            6: step(1'b0, 8'h14, 0, "");
            7: step(1'b0, 8'h18, 0, "");
            8: step(1'b1, 8'h04, $urandom, "");
            9: step(1'b1, 8'h00, {31'b0, 1'($urandom % 5 != 0)}, "");
            10: step(1'b0, 8'h04, 0, "");
            default: step(1'b0, 8'h00, 0, "");
         endcase
      end
      finish_up();
   end
endmodule